// File: doc/BRIEF.md
# Single-Channel Block Copy DMA Engine

This block is one DMA channel that copies a block of bytes from a source address to a destination address. Each copy is a read/write pair carried over a simple bus-master port: a request is held with `bus_req` until `bus_gnt` accepts it, and the answer comes back later as one `bus_ack` or `bus_err` pulse. Software sets the source, destination, byte count and control registers through a small register port. It then starts the channel either with a self-clearing start bit, or by letting the `dma_req` pin trigger it.

Before any bus traffic the engine checks the settings. Each address must sit on a boundary of its own access size, the count must be a non-zero multiple of both sizes, and both size codes must be legal. A failed check raises the configuration-error flag and the bus stays untouched. Each move carries as many bytes as the wider of the two access sizes. A wide read is split into several narrow writes, and several narrow reads are merged into one wide write, in little-endian byte order. A bandwidth field can make the engine leave its request low for one extra cycle at count boundaries, so that an arbiter can hand the bus to another master. A bus error halts the channel and locks it until software clears the status.

Top module: `sdma_engine`

## Requirements
- R1: After reset every register reads 0, and `bus_req` and `irq` are low.
- R2: Control bit 16 (start) begins a transfer and reads back 0 once the channel has launched. The first bus request is a read of the source address.
- R3: When control bit 30 (external enable) is set, a high `dma_req` launches the channel. `dma_req` has no effect while bit 30 is clear, and bit 30 alone does nothing while `dma_req` is low.
- R4: The size codes are control bits 21:20 (source) and 18:17 (destination): 00 is 4 bytes, 01 is 1 byte, 10 is 2 bytes, and 11 is illegal. Any of the following sets status bit 6 (configuration error) and makes no bus request: an illegal code, a zero count, a count that is not a multiple of the move size, or an address that is off its size boundary.
- R5: When control bit 28 (auto-align) is set, address alignment is not checked, and the low address bits are cleared to the access-size boundary on the bus.
- R6: Each move carries max(source size, destination size) bytes. A wider read is split into narrower writes and narrower reads are merged into a wider write, with the lowest byte first.
- R7: An accepted read address phase advances the source register by the source size when control bit 22 is set. An accepted write address phase advances the destination register by the destination size when control bit 19 is set. A cleared bit leaves its register fixed, and a stalled request (`bus_gnt` low) moves neither register.
- R8: Each accepted write address phase lowers the count by the destination size. Status bit 0 (done) is set when the last write is acknowledged with the count at zero.
- R9: A `bus_err` response sets status bits 5 and 0 and halts the channel. While bit 5 stays set, start requests are ignored.
- R10: Control bits 27:25 give k. When k is non-zero and the count left after a move is a non-zero multiple of 2^(k+3), `bus_req` stays low for one extra cycle before the next read.
- R11: `irq` equals control bit 31 AND (done OR configuration error). Writing a 1 to status bit 0 clears all status flags.
- R12: While the channel is busy (status bit 1), writes to the address, count and control registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 source, 1 destination, 2 count, 3 control, 4 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dma_req | input | 1 | External transfer request |
| irq | output | 1 | Interrupt |
| bus_req | output | 1 | Bus request valid |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Write data, right-aligned |
| bus_gnt | input | 1 | Request accepted this cycle |
| bus_ack | input | 1 | Beat completed |
| bus_err | input | 1 | Beat terminated with error |
| bus_rdata | input | 32 | Read data, right-aligned, valid with `bus_ack` |

## Verification
A register write takes effect on the next edge, and the launch decision follows one edge after that. Status, address and count results are therefore read only after the engine has returned to idle. For a configuration error, status is read two cycles after the control write. The bench bus model grants at once and answers one cycle after acceptance, so a 4-byte move takes exactly four cycles, two of them with the request low. The bandwidth release is checked as exactly one extra request-low cycle in an otherwise identical run. Every output is sampled on the falling edge, half a cycle after the edge that produced it.

// File: rtl/sdma_pkg.sv
// Shared definitions for the single-channel DMA engine: register indices,
// control and status bit positions, FSM state type and size decoding.
package sdma_pkg;

    localparam logic [2:0] REG_SRC  = 3'd0;
    localparam logic [2:0] REG_DST  = 3'd1;
    localparam logic [2:0] REG_CNT  = 3'd2;
    localparam logic [2:0] REG_CTL  = 3'd3;
    localparam logic [2:0] REG_STAT = 3'd4;

    localparam int CTL_START = 16;
    localparam int CTL_DSZ   = 17;   // two bits
    localparam int CTL_DINC  = 19;
    localparam int CTL_SSZ   = 20;   // two bits
    localparam int CTL_SINC  = 22;
    localparam int CTL_BWC   = 25;   // three bits
    localparam int CTL_AA    = 28;
    localparam int CTL_EEXT  = 30;
    localparam int CTL_IE    = 31;

    localparam int ST_DONE = 0;
    localparam int ST_BUSY = 1;
    localparam int ST_BES  = 5;
    localparam int ST_CE   = 6;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_A, S_RD_D, S_WR_A, S_WR_D, S_PAUSE
    } sdma_state_t;

    // Bytes per access for a size code; 0 marks the illegal code.
    function automatic logic [2:0] size_bytes(input logic [1:0] enc);
        case (enc)
            2'b00:   size_bytes = 3'd4;
            2'b01:   size_bytes = 3'd1;
            2'b10:   size_bytes = 3'd2;
            default: size_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdma_cfg_check.sv
// Configuration checker. Decodes both access sizes and the move size
// (the larger of the two), and decides whether the programmed addresses and
// count permit a transfer. Purely combinational; it assumes the inputs
// are stable register values.
module sdma_cfg_check
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [1:0]        ssize,
    input  logic [1:0]        dsize,
    input  logic              auto_align,
    output logic [2:0]        sbytes,
    output logic [2:0]        dbytes,
    output logic [2:0]        chunk,
    output logic [1:0]        smask,
    output logic [1:0]        dmask,
    output logic              cfg_ok
);
    logic [1:0] cmask;
    logic       size_ok, addr_ok, cnt_ok;

    // Size decode, alignment masks and the final verdict.
    always_comb begin
        sbytes  = size_bytes(ssize);
        dbytes  = size_bytes(dsize);
        chunk   = (sbytes > dbytes) ? sbytes : dbytes;
        smask   = 2'(sbytes - 3'd1);
        dmask   = 2'(dbytes - 3'd1);
        cmask   = 2'(chunk - 3'd1);
        size_ok = (sbytes != 3'd0) && (dbytes != 3'd0);
        addr_ok = ((src[1:0] & smask) == 2'b00) && ((dst[1:0] & dmask) == 2'b00);
        cnt_ok  = (cnt != '0) && ((cnt[1:0] & cmask) == 2'b00);
        cfg_ok  = size_ok && cnt_ok && (auto_align || addr_ok);
    end
endmodule

// File: rtl/sdma_lane_buf.sv
// Byte-lane staging buffer. Each read beat is merged into the byte offset
// it covers inside the current move, and each write beat takes its data from
// its own offset. Assumes offset + size never exceeds four bytes.
module sdma_lane_buf (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [1:0]  rd_off,
    input  logic [2:0]  sbytes,
    input  logic [31:0] rdata,
    input  logic [1:0]  wr_off,
    output logic [31:0] wdata
);
    logic [31:0] stage_q;
    logic [31:0] lane_mask;

    // Mask of the bytes one read beat carries.
    always_comb begin
        case (sbytes)
            3'd1:    lane_mask = 32'h0000_00ff;
            3'd2:    lane_mask = 32'h0000_ffff;
            default: lane_mask = 32'hffff_ffff;
        endcase
    end

    // Merge an acknowledged read beat into its lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (load) begin
            stage_q <= (stage_q & ~(lane_mask << {rd_off, 3'b000}))
                     | ((rdata & lane_mask) << {rd_off, 3'b000});
        end
    end

    // Right-align the bytes of the current write beat.
    assign wdata = stage_q >> {wr_off, 3'b000};
endmodule

// File: rtl/sdma_engine.sv
// Single-channel dual-address DMA engine. Holds the source, destination,
// count, control and status registers and sequences read/write beats on a
// valid/ready bus with one response per beat. Assumes the bus answers each
// accepted beat with exactly one ack or err pulse, some cycles later.
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dma_req,
    output logic              irq,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [31:0]       bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [31:0]       bus_rdata
);
    sdma_state_t       state;
    logic [ADDR_W-1:0] sar, dar;
    logic [CNT_W-1:0]  bcr;
    logic [31:0]       ctrl;
    logic              st_done, st_bes, st_ce;
    logic [1:0]        rd_off, wr_off;

    logic [2:0]        sb, db, chunk;
    logic [1:0]        smask, dmask;
    logic              cfg_ok, go, launch, busy, rd_last, wr_last, at_block;
    logic [CNT_W-1:0]  blk_mask;
    logic [ADDR_W-1:0] src_eff, dst_eff;

    sdma_cfg_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_check (
        .src(sar), .dst(dar), .cnt(bcr),
        .ssize(ctrl[CTL_SSZ +: 2]), .dsize(ctrl[CTL_DSZ +: 2]),
        .auto_align(ctrl[CTL_AA]),
        .sbytes(sb), .dbytes(db), .chunk(chunk),
        .smask(smask), .dmask(dmask), .cfg_ok(cfg_ok)
    );

    sdma_lane_buf u_buf (
        .clk(clk), .rst_n(rst_n),
        .load(state == S_RD_D && bus_ack && !bus_err),
        .rd_off(rd_off), .sbytes(sb), .rdata(bus_rdata),
        .wr_off(wr_off), .wdata(bus_wdata)
    );

    // Launch conditions, beat bookkeeping and the bandwidth boundary test.
    always_comb begin
        busy     = (state != S_IDLE);
        go       = ctrl[CTL_START] || (ctrl[CTL_EEXT] && dma_req);
        launch   = (state == S_IDLE) && go && !st_bes;
        rd_last  = (({1'b0, rd_off} + sb) == chunk);
        wr_last  = (({1'b0, wr_off} + db) == chunk);
        blk_mask = (CNT_W'(1) << (4'(ctrl[CTL_BWC +: 3]) + 4'd3)) - CNT_W'(1);
        at_block = (ctrl[CTL_BWC +: 3] != 3'd0) && ((bcr & blk_mask) == '0);
        src_eff  = ctrl[CTL_AA] ? {sar[ADDR_W-1:2], sar[1:0] & ~smask} : sar;
        dst_eff  = ctrl[CTL_AA] ? {dar[ADDR_W-1:2], dar[1:0] & ~dmask} : dar;
    end

    // Bus master outputs, decoded from the state.
    assign bus_req  = (state == S_RD_A) || (state == S_WR_A);
    assign bus_we   = (state == S_WR_A);
    assign bus_addr = bus_we ? dst_eff : src_eff;
    assign bus_size = bus_we ? ctrl[CTL_DSZ +: 2] : ctrl[CTL_SSZ +: 2];
    assign irq      = ctrl[CTL_IE] && (st_done || st_ce);

    // Register read mux.
    always_comb begin
        case (reg_addr)
            REG_SRC:  reg_rdata = 32'(sar);
            REG_DST:  reg_rdata = 32'(dar);
            REG_CNT:  reg_rdata = 32'(bcr);
            REG_CTL:  reg_rdata = ctrl;
            REG_STAT: reg_rdata = {25'd0, st_ce, st_bes, 3'd0, busy, st_done};
            default:  reg_rdata = '0;
        endcase
    end

    // Transfer sequencer and register file; software writes come last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            sar     <= '0;
            dar     <= '0;
            bcr     <= '0;
            ctrl    <= '0;
            st_done <= 1'b0;
            st_bes  <= 1'b0;
            st_ce   <= 1'b0;
            rd_off  <= '0;
            wr_off  <= '0;
        end else begin
            case (state)
                S_IDLE: if (launch) begin
                    ctrl[CTL_START] <= 1'b0;
                    if (cfg_ok) begin
                        state  <= S_RD_A;
                        rd_off <= '0;
                        wr_off <= '0;
                    end else begin
                        st_ce <= 1'b1;
                    end
                end
                S_RD_A: if (bus_gnt) begin
                    if (ctrl[CTL_SINC]) sar <= sar + ADDR_W'(sb);
                    state <= S_RD_D;
                end
                S_RD_D: if (bus_err) begin
                    st_bes <= 1'b1;
                    st_done <= 1'b1;
                    state <= S_IDLE;
                end else if (bus_ack) begin
                    if (rd_last) begin
                        wr_off <= '0;
                        state  <= S_WR_A;
                    end else begin
                        rd_off <= rd_off + 2'(sb);
                        state  <= S_RD_A;
                    end
                end
                S_WR_A: if (bus_gnt) begin
                    if (ctrl[CTL_DINC]) dar <= dar + ADDR_W'(db);
                    bcr   <= bcr - CNT_W'(db);
                    state <= S_WR_D;
                end
                S_WR_D: if (bus_err) begin
                    st_bes <= 1'b1;
                    st_done <= 1'b1;
                    state <= S_IDLE;
                end else if (bus_ack) begin
                    if (!wr_last) begin
                        wr_off <= wr_off + 2'(db);
                        state  <= S_WR_A;
                    end else begin
                        rd_off <= '0;
                        if (bcr == '0) begin
                            st_done <= 1'b1;
                            state   <= S_IDLE;
                        end else if (at_block) begin
                            state <= S_PAUSE;
                        end else begin
                            state <= S_RD_A;
                        end
                    end
                end
                S_PAUSE: state <= S_RD_A;
                default: state <= S_IDLE;
            endcase

            if (reg_we) begin
                if (reg_addr == REG_STAT) begin
                    if (reg_wdata[ST_DONE]) begin
                        st_done <= 1'b0;
                        st_bes  <= 1'b0;
                        st_ce   <= 1'b0;
                    end
                end else if (!busy) begin
                    case (reg_addr)
                        REG_SRC: sar  <= ADDR_W'(reg_wdata);
                        REG_DST: dar  <= ADDR_W'(reg_wdata);
                        REG_CNT: bcr  <= CNT_W'(reg_wdata);
                        REG_CTL: ctrl <= reg_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    // R2: a good launch moves to the read phase with start already cleared.
    a_r2_start_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && cfg_ok && !reg_we) |=> (state == S_RD_A && !ctrl[CTL_START]));

    // R4: a rejected configuration raises CE and never leaves idle.
    a_r4_bad_cfg_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !cfg_ok && !reg_we) |=> (state == S_IDLE && st_ce));

    // R7: a stalled request leaves both addresses untouched.
    a_r7_stall_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> ($stable(sar) && $stable(dar)));

    // R8: an accepted write lowers the count by the destination size.
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_gnt) |=> (bcr == $past(bcr) - CNT_W'($past(db))));

    // R9: an error response halts the channel with BES and DONE set.
    a_r9_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_RD_D || state == S_WR_D) && bus_err)
        |=> (state == S_IDLE && st_bes && st_done));

    // R9: a latched bus error keeps the channel idle.
    a_r9_bes_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && st_bes) |=> (state == S_IDLE));

    // R10: the release cycle only happens on a non-zero block boundary.
    a_r10_pause_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAUSE) |-> (at_block && bcr != '0));
endmodule

// File: tb/sdma_engine_tb.sv
`timescale 1ns/1ps
module sdma_engine_tb;
    localparam logic [31:0] C_START = 32'h1 << 16;
    localparam logic [31:0] C_DINC  = 32'h1 << 19;
    localparam logic [31:0] C_SINC  = 32'h1 << 22;
    localparam logic [31:0] C_AA    = 32'h1 << 28;
    localparam logic [31:0] C_EEXT  = 32'h1 << 30;
    localparam logic [31:0] C_IE    = 32'h1 << 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dma_req = 1'b0;
    logic        irq, bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic        bus_gnt;
    logic        bus_ack = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    logic        gnt = 1'b1;
    logic        err_en = 1'b0;
    logic [7:0]  err_addr = 8'h00;
    logic [7:0]  mem [0:255];
    int          n_chk = 0, n_fail = 0;
    int          n_rd = 0, n_wr = 0, n_req = 0, n_quiet = 0;

    assign bus_gnt = gnt;
    always #2 clk = ~clk;

    sdma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
        .irq(irq), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    function automatic int nbytes(input logic [1:0] c);
        return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 4;
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7) + 3);
    endfunction

    // Behavioural memory: answers one cycle after acceptance, with optional error.
    always @(posedge clk) begin
        bus_ack <= 1'b0;
        bus_err <= 1'b0;
        if (bus_req && bus_gnt) begin
            if (err_en && bus_addr[7:0] == err_addr) begin
                bus_err <= 1'b1;
            end else begin
                bus_ack <= 1'b1;
                if (bus_we) begin
                    for (int k = 0; k < 4; k++)
                        if (k < nbytes(bus_size))
                            mem[8'(bus_addr[7:0] + 8'(k))] <= bus_wdata[8*k +: 8];
                end else begin
                    bus_rdata <= {mem[8'(bus_addr[7:0] + 8'd3)], mem[8'(bus_addr[7:0] + 8'd2)],
                                  mem[8'(bus_addr[7:0] + 8'd1)], mem[bus_addr[7:0]]};
                end
            end
        end
    end

    // Bus activity monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (bus_req) n_req++;
        if (bus_req && bus_gnt && !bus_we) n_rd++;
        if (bus_req && bus_gnt && bus_we) n_wr++;
        if (reg_addr == 3'd4 && reg_rdata[1] && !bus_req) n_quiet++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_rd = 0; n_wr = 0; n_req = 0; n_quiet = 0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        bit ok = 1'b0;
        reg_addr = 3'd4;
        @(negedge clk);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!reg_rdata[1]) begin ok = 1'b1; break; end
        end
        if (!ok) check({tag, " timeout"}, 32'd1, 32'd0);
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
        wr_reg(3'd4, 32'h1);
        wr_reg(3'd0, s);
        wr_reg(3'd1, d);
        wr_reg(3'd2, c);
        clr_mon();
    endtask

    task automatic cmp_block(input string tag, input int d, input int s, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) if (mem[8'(d + i)] !== pat(s + i)) bad++;
        check(tag, 32'(bad), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            rd_reg(3'(a), v);
            check("R1 register reset value", v, 32'd0);
        end
        check("R1 bus_req after reset", 32'(bus_req), 32'd0);
        check("R1 irq after reset", 32'(irq), 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        setup(32'h10, 32'h80, 32'd16);
        wr_reg(3'd3, C_IE | C_SINC | C_DINC | C_START);
        wait_idle("R2 basic");
        cmp_block("R2 word copy data", 32'h80, 32'h10, 16);
        rd_reg(3'd4, v); check("R8 done status", v, 32'h1);
        rd_reg(3'd2, v); check("R8 count at zero", v, 32'd0);
        rd_reg(3'd0, v); check("R7 source advanced", v, 32'h20);
        rd_reg(3'd1, v); check("R7 destination advanced", v, 32'h90);
        rd_reg(3'd3, v); check("R2 start bit self-cleared", v[16], 1'b0);
        check("R2 read beats", 32'(n_rd), 32'd4);
        check("R8 write beats", 32'(n_wr), 32'd4);
        check("R11 irq on done", 32'(irq), 32'd1);
        wr_reg(3'd4, 32'h1);
        rd_reg(3'd4, v); check("R11 status cleared", v, 32'd0);
        check("R11 irq cleared", 32'(irq), 32'd0);
    endtask

    task automatic t_split();
        logic [31:0] v;
        setup(32'h20, 32'hA0, 32'd8);
        wr_reg(3'd3, (32'h1 << 17) | C_SINC | C_DINC | C_START);
        wait_idle("R6 split");
        cmp_block("R6 word to byte data", 32'hA0, 32'h20, 8);
        check("R6 split read beats", 32'(n_rd), 32'd2);
        check("R6 split write beats", 32'(n_wr), 32'd8);
        rd_reg(3'd1, v); check("R7 byte destination step", v, 32'hA8);
    endtask

    task automatic t_merge();
        setup(32'h30, 32'hB0, 32'd4);
        wr_reg(3'd3, (32'h1 << 20) | (32'h2 << 17) | C_SINC | C_DINC | C_START);
        wait_idle("R6 merge");
        cmp_block("R6 byte to half data", 32'hB0, 32'h30, 4);
        check("R6 merge read beats", 32'(n_rd), 32'd4);
        check("R6 merge write beats", 32'(n_wr), 32'd2);
    endtask

    task automatic t_fixed_dst();
        logic [31:0] v;
        setup(32'h40, 32'hC0, 32'd3);
        wr_reg(3'd3, (32'h1 << 20) | (32'h1 << 17) | C_SINC | C_START);
        wait_idle("R7 fixed");
        check("R7 fixed destination last byte", 32'(mem[8'hC0]), 32'(pat(32'h42)));
        check("R7 next byte untouched", 32'(mem[8'hC1]), 32'(pat(32'hC1)));
        rd_reg(3'd1, v); check("R7 destination held", v, 32'hC0);
        rd_reg(3'd0, v); check("R7 source stepped by bytes", v, 32'h43);
    endtask

    task automatic cfg_case(input string tag, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] c, input logic [31:0] ctl);
        logic [31:0] v;
        setup(s, d, c);
        wr_reg(3'd3, ctl | C_START);
        repeat (3) @(negedge clk);
        rd_reg(3'd4, v); check({tag, " CE flag"}, v, 32'h40);
        check({tag, " no bus request"}, 32'(n_req), 32'd0);
    endtask

    task automatic t_cfg();
        cfg_case("R4 misaligned source", 32'h11, 32'h80, 32'd4, C_IE);
        check("R11 irq on CE", 32'(irq), 32'd1);
        cfg_case("R4 count not multiple", 32'h10, 32'h80, 32'd6, 32'd0);
        cfg_case("R4 zero count", 32'h10, 32'h80, 32'd0, 32'd0);
        cfg_case("R4 illegal size code", 32'h10, 32'h80, 32'd4, 32'h3 << 20);
        cfg_case("R4 misaligned half destination", 32'h10, 32'h81, 32'd4, 32'h2 << 17);
        wr_reg(3'd4, 32'h1);
    endtask

    task automatic t_autoalign();
        logic [31:0] v;
        setup(32'h13, 32'hD0, 32'd4);
        wr_reg(3'd3, C_AA | C_SINC | C_DINC | C_START);
        wait_idle("R5 auto-align");
        rd_reg(3'd4, v); check("R5 no CE with auto-align", v, 32'h1);
        cmp_block("R5 masked source data", 32'hD0, 32'h10, 4);
    endtask

    task automatic t_ext();
        logic [31:0] v;
        setup(32'h50, 32'hE0, 32'd4);
        dma_req = 1'b1;
        wr_reg(3'd3, C_SINC | C_DINC);
        repeat (10) @(negedge clk);
        check("R3 pin ignored without enable", 32'(n_req), 32'd0);
        dma_req = 1'b0;
        wr_reg(3'd3, C_EEXT | C_SINC | C_DINC);
        repeat (10) @(negedge clk);
        check("R3 enable alone does nothing", 32'(n_req), 32'd0);
        dma_req = 1'b1;
        @(negedge clk);
        dma_req = 1'b0;
        wait_idle("R3 external");
        rd_reg(3'd4, v); check("R3 external run done", v, 32'h1);
        cmp_block("R3 external copy data", 32'hE0, 32'h50, 4);
        wr_reg(3'd3, 32'd0);
    endtask

    task automatic t_buserr();
        logic [31:0] v;
        setup(32'h60, 32'hF0, 32'd8);
        err_en = 1'b1; err_addr = 8'hF4;
        wr_reg(3'd3, C_SINC | C_DINC | C_START);
        wait_idle("R9 error");
        rd_reg(3'd4, v); check("R9 BES and DONE", v, 32'h21);
        check("R9 stopped at failing write", 32'(n_wr), 32'd2);
        err_en = 1'b0;
        clr_mon();
        wr_reg(3'd2, 32'd4);
        wr_reg(3'd3, C_SINC | C_DINC | C_START);
        repeat (5) @(negedge clk);
        check("R9 start blocked while BES", 32'(n_req), 32'd0);
        rd_reg(3'd4, v); check("R9 status kept", v, 32'h21);
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd4, 32'h1);
    endtask

    task automatic bwc_run(input logic [2:0] k, input int exp_quiet);
        setup(32'h00, 32'h80, 32'd32);
        wr_reg(3'd3, (32'(k) << 25) | C_SINC | C_DINC | C_START);
        wait_idle("R10 bandwidth");
        check($sformatf("R10 request-low cycles k=%0d", k), 32'(n_quiet), 32'(exp_quiet));
    endtask

    task automatic t_bwc();
        bwc_run(3'd0, 16);
        bwc_run(3'd1, 17);
        bwc_run(3'd2, 16);
        cmp_block("R10 data intact", 32'h80, 32'h00, 32);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        setup(32'h10, 32'h80, 32'd4);
        gnt = 1'b0;
        wr_reg(3'd3, C_SINC | C_DINC | C_START);
        repeat (3) @(negedge clk);
        check("R7 stalled request held", 32'(bus_req), 32'd1);
        wr_reg(3'd0, 32'h99);
        rd_reg(3'd0, v); check("R12 source write ignored while busy", v, 32'h10);
        rd_reg(3'd4, v); check("R12 busy flag", v, 32'h2);
        gnt = 1'b1;
        wait_idle("R12 resume");
        rd_reg(3'd0, v); check("R12 source after run", v, 32'h14);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] <= pat(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_split();
        t_merge();
        t_fixed_dst();
        t_cfg();
        t_autoalign();
        t_ext();
        t_buserr();
        t_bwc();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule